// File: doc/BRIEF.md
# Rename Stage Flow Controller

This block decides, every clock cycle, how many decoded instructions a single-thread register-rename stage passes on to the back end. Up to `W` instructions arrive from decode per cycle, each carrying a small tag and kind bits: load, store, atomic, serialize-before, serialize-after and squashed. The back end reports its free reorder-buffer, issue-queue, load-queue and store-queue entries. A general stall, a squash and a "reorder buffer empty" indication complete the inputs. Register mapping is not performed here. The block only throttles, orders and holds instructions.

Instructions that cannot go on are parked in a skid buffer. Whenever that buffer holds anything, it is the only source the block renames from. A level `block_o` tells decode to stop sending. A one-cycle `unblock_o` pulse tells decode it may resume, once the buffer has drained. Serializing instructions are handled as follows. An instruction that must serialize before itself waits in a hold register until the reorder buffer is empty. An instruction that serializes after itself forces the following instruction to serialize before.

All outputs are registered. A decision made on the inputs of one cycle appears on the outputs after the next rising edge.

Top module: `rename_flow_ctrl`

## Requirements
- R1: With no stall condition, the count sent is the smallest of the instructions available, the free reorder-buffer entries and the free issue-queue entries. The sent instructions appear packed in arrival order in `out_bus`, slot k at bits [k*12 +: 12]. Within a slot, bits [5:0] are the tag, bit 6 is load, bit 7 is store, bit 8 is atomic, bit 9 is serialize-before, bit 10 is serialize-after and bit 11 is squashed.
- R2: Any of the following blocks the stage: `stall_in` high, or a zero count of free reorder-buffer, issue-queue, load-queue or store-queue entries. The stage then sends nothing that cycle, enters BLOCKED and raises `block_o`.
- R3: A load needs a free load-queue entry. A store or an atomic needs a free store-queue entry. At the first instruction that lacks one, sending stops, and that instruction and those after it are kept in order. The same holds when the free-entry minimum of R1 cut the group short. In either case the stage enters BLOCKED.
- R4: Kept instructions, and decode input that arrives while the stage is not renaming, enter a skid buffer of `DEPTH` entries. Pushing past `DEPTH` sets `skid_ovf_o`, which stays set until reset.
- R5: A BLOCKED stage whose stall condition has cleared moves to UNBLOCKING and sends nothing that cycle. While the skid buffer is non-empty, it is the only source. When it empties, the stage goes to RUNNING and pulses `unblock_o` for one cycle.
- R6: A squash overrides every other input. The outputs then show no instructions and the state SQUASHING. The skid buffer and that cycle's decode input are dropped.
- R7: In the first cycle without squash, SQUASHING moves to one of three states. It goes to SERIALIZE_STALL if a serialize stall was pending when the squash arrived. Otherwise it goes to UNBLOCKING if the stage was unblocking. Otherwise it goes to RUNNING.
- R8: An unhandled serialize-before instruction ends the group and is held, and the stage enters SERIALIZE_STALL. It is released when `rob_empty` is high and there is no stall condition. It is then sent alone, with its serialize-before bit cleared, and the stage moves to UNBLOCKING.
- R9: A sent serialize-after instruction makes the next instruction serialize-before. When no next instruction is present, the mark is remembered and applied to the next instruction that arrives.
- R10: Squashed instructions are consumed without being sent.
- R11: `state_o` encodes the states as IDLE=0, RUNNING=1, BLOCKED=2, UNBLOCKING=3, SQUASHING=4 and SERIALIZE_STALL=5. A running stage with nothing to send goes to IDLE.
- R12: After reset, the state is IDLE, `out_n` is 0, and `block_o`, `unblock_o` and `skid_ovf_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_n | input | CW | Number of valid decode slots this cycle |
| dec_bus | input | W*12 | Decode instructions, slot 0 in the low bits |
| free_rob | input | FW | Free reorder-buffer entries |
| free_iq | input | FW | Free issue-queue entries |
| free_lq | input | FW | Free load-queue entries |
| free_sq | input | FW | Free store-queue entries |
| rob_empty | input | 1 | Reorder buffer holds nothing |
| stall_in | input | 1 | Stall request from downstream |
| squash | input | 1 | Discard all in-flight instructions |
| out_n | output | CW | Number of instructions sent |
| out_bus | output | W*12 | Sent instructions, packed from slot 0 |
| block_o | output | 1 | Decode must hold its input |
| unblock_o | output | 1 | One-cycle resume pulse to decode |
| state_o | output | 3 | Current state code |
| skid_ovf_o | output | 1 | Sticky skid-buffer overflow flag |

## Verification
Each output is due one rising edge after the inputs that produce it. The bench drives inputs a quarter period after an edge and reads results a quarter period after the following edge, so every check counts exactly one register stage. Multi-step behaviour is checked one cycle at a time, with the expected state fixed for each step. This covers the BLOCKED to UNBLOCKING hop, the draining of the skid buffer, the wait on `rob_empty` and the exit from squash. Sweeps over the free-entry counts and group sizes compute the expected count and state arithmetically from R1 to R3.

// File: rtl/rnfc_pkg.sv
package rnfc_pkg;
    localparam int TAG_W = 6;

    typedef struct packed {
        logic             squashed;
        logic             ser_after;
        logic             ser_before;
        logic             atomic;
        logic             store;
        logic             load;
        logic [TAG_W-1:0] tag;
    } ren_inst_t;

    localparam int INST_W = $bits(ren_inst_t);

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_BLOCK  = 3'd2,
        ST_UNBLK  = 3'd3,
        ST_SQUASH = 3'd4,
        ST_SERSTL = 3'd5
    } ren_state_t;
endpackage

// File: rtl/rnfc_skid.sv
module rnfc_skid
    import rnfc_pkg::*;
#(
    parameter int W     = 4,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(W + 1),
    parameter int QW    = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic [CW-1:0]          pop_n,
    input  logic [CW-1:0]          push_n,
    input  ren_inst_t [W-1:0]      push_data,
    output ren_inst_t [W-1:0]      head_data,
    output logic [QW-1:0]          fill,
    output logic                   ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        ren_inst_t [DEPTH-1:0] mem;
        logic [PW-1:0]         head;
        logic [QW-1:0]         fill;
        logic                  ovf;
    } skid_t;

    skid_t s_q, s_d;

    always_comb begin
        int keep;
        int base;
        int nok;
        s_d  = s_q;
        keep = 0;
        base = 0;
        nok  = 0;
        if (clr) begin
            s_d.head = '0;
            s_d.fill = '0;
        end else begin
            keep = int'(s_q.fill) - int'(pop_n);
            if (keep < 0) keep = 0;
            base = (int'(s_q.head) + int'(pop_n)) % DEPTH;
            for (int i = 0; i < W; i++) begin
                if (i < int'(push_n)) begin
                    if (keep + i < DEPTH) begin
                        s_d.mem[(base + keep + i) % DEPTH] = push_data[i];
                        nok++;
                    end else begin
                        s_d.ovf = 1'b1;
                    end
                end
            end
            s_d.head = PW'(base);
            s_d.fill = QW'(keep + nok);
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            head_data[i] = s_q.mem[(int'(s_q.head) + i) % DEPTH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fill = s_q.fill;
    assign ovf  = s_q.ovf;
endmodule

// File: rtl/rnfc_select.sv
module rnfc_select
    import rnfc_pkg::*;
#(
    parameter int W  = 4,
    parameter int CW = $clog2(W + 1),
    parameter int FW = 6
) (
    input  ren_inst_t [W-1:0] src,
    input  logic [CW-1:0]     avail,
    input  logic [FW-1:0]     free_rob,
    input  logic [FW-1:0]     free_iq,
    input  logic [FW-1:0]     free_lq,
    input  logic [FW-1:0]     free_sq,
    input  logic              carry_in,
    output logic [CW-1:0]     consumed,
    output logic [CW-1:0]     emit_n,
    output ren_inst_t [W-1:0] emit,
    output logic              cap_v,
    output ren_inst_t         cap_inst,
    output logic              res_stop,
    output logic              carry_out
);
    always_comb begin
        int lim;
        int lq_used;
        int sq_used;
        int ne;
        int nc;
        logic go;
        logic carry;
        logic sbf;
        ren_inst_t e;
        lim = int'(avail);
        if (int'(free_rob) < lim) lim = int'(free_rob);
        if (int'(free_iq) < lim)  lim = int'(free_iq);
        go       = 1'b1;
        carry    = carry_in;
        sbf      = 1'b0;
        lq_used  = 0;
        sq_used  = 0;
        ne       = 0;
        nc       = 0;
        emit     = '0;
        cap_v    = 1'b0;
        cap_inst = '0;
        res_stop = 1'b0;
        for (int i = 0; i < W; i++) begin
            e = src[i];
            if (go && i < lim) begin
                sbf = e.ser_before | carry;
                if (e.squashed) begin
                    nc++;
                end else if (sbf) begin
                    cap_v               = 1'b1;
                    cap_inst            = e;
                    cap_inst.ser_before = 1'b0;
                    carry               = 1'b0;
                    go                  = 1'b0;
                    nc++;
                end else if (e.load && lq_used >= int'(free_lq)) begin
                    res_stop = 1'b1;
                    go       = 1'b0;
                end else if ((e.store | e.atomic) && sq_used >= int'(free_sq)) begin
                    res_stop = 1'b1;
                    go       = 1'b0;
                end else begin
                    emit[ne] = e;
                    ne++;
                    nc++;
                    carry = e.ser_after;
                    if (e.load) lq_used++;
                    if (e.store | e.atomic) sq_used++;
                end
            end
        end
        if (go && lim < int'(avail)) res_stop = 1'b1;
        consumed  = CW'(nc);
        emit_n    = CW'(ne);
        carry_out = carry;
    end
endmodule

// File: rtl/rename_flow_ctrl.sv
module rename_flow_ctrl
    import rnfc_pkg::*;
#(
    parameter int W     = 4,
    parameter int DEPTH = 2 * W,
    parameter int FW    = 6,
    parameter int CW    = $clog2(W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     dec_n,
    input  logic [W*12-1:0]   dec_bus,
    input  logic [FW-1:0]     free_rob,
    input  logic [FW-1:0]     free_iq,
    input  logic [FW-1:0]     free_lq,
    input  logic [FW-1:0]     free_sq,
    input  logic              rob_empty,
    input  logic              stall_in,
    input  logic              squash,
    output logic [CW-1:0]     out_n,
    output logic [W*12-1:0]   out_bus,
    output logic              block_o,
    output logic              unblock_o,
    output logic [2:0]        state_o,
    output logic              skid_ovf_o
);
    localparam int IW = INST_W;
    localparam int QW = $clog2(DEPTH + 1);

    typedef struct packed {
        ren_state_t        state;
        logic              ser_next;
        ren_inst_t         hold;
        logic              res_ser;
        logic              res_unb;
        logic [CW-1:0]     out_n;
        ren_inst_t [W-1:0] out_data;
        logic              unblock;
    } ctl_t;

    ctl_t c_q, c_d;

    ren_inst_t [W-1:0] dec_arr;
    logic [CW-1:0]     dec_v;

    generate
        for (genvar g = 0; g < W; g++) begin : g_unpack
            assign dec_arr[g] = ren_inst_t'(dec_bus[g*IW +: IW]);
        end
    endgenerate

    assign dec_v = (int'(dec_n) > W) ? CW'(W) : dec_n;

    // skid buffer
    logic              sk_clr;
    logic [CW-1:0]     sk_pop;
    logic [CW-1:0]     sk_push_n;
    ren_inst_t [W-1:0] sk_push;
    ren_inst_t [W-1:0] sk_head;
    logic [QW-1:0]     sk_fill;
    logic              sk_ovf;

    rnfc_skid #(.W(W), .DEPTH(DEPTH), .CW(CW), .QW(QW)) i_skid (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sk_clr),
        .pop_n     (sk_pop),
        .push_n    (sk_push_n),
        .push_data (sk_push),
        .head_data (sk_head),
        .fill      (sk_fill),
        .ovf       (sk_ovf)
    );

    // source selection: skid buffer strictly before decode input
    logic              use_skid;
    ren_inst_t [W-1:0] sel_src;
    logic [CW-1:0]     sel_avail;

    always_comb begin
        use_skid  = (sk_fill != '0);
        sel_src   = use_skid ? sk_head : dec_arr;
        if (use_skid) sel_avail = (int'(sk_fill) > W) ? CW'(W) : CW'(sk_fill);
        else          sel_avail = dec_v;
    end

    logic [CW-1:0]     sel_cons;
    logic [CW-1:0]     sel_emit_n;
    ren_inst_t [W-1:0] sel_emit;
    logic              sel_cap;
    ren_inst_t         sel_cap_inst;
    logic              sel_stop;
    logic              sel_carry;

    rnfc_select #(.W(W), .CW(CW), .FW(FW)) i_select (
        .src       (sel_src),
        .avail     (sel_avail),
        .free_rob  (free_rob),
        .free_iq   (free_iq),
        .free_lq   (free_lq),
        .free_sq   (free_sq),
        .carry_in  (c_q.ser_next),
        .consumed  (sel_cons),
        .emit_n    (sel_emit_n),
        .emit      (sel_emit),
        .cap_v     (sel_cap),
        .cap_inst  (sel_cap_inst),
        .res_stop  (sel_stop),
        .carry_out (sel_carry)
    );

    logic stall_c;
    assign stall_c = stall_in || (free_rob == '0) || (free_iq == '0) ||
                     (free_lq == '0) || (free_sq == '0);

    always_comb begin
        int cons_i;
        int rem_i;
        c_d          = c_q;
        c_d.out_n    = '0;
        c_d.out_data = '0;
        c_d.unblock  = 1'b0;
        sk_clr       = 1'b0;
        sk_pop       = '0;
        sk_push_n    = '0;
        sk_push      = dec_arr;
        cons_i       = 0;
        rem_i        = 0;
        if (squash) begin
            c_d.state    = ST_SQUASH;
            c_d.ser_next = 1'b0;
            c_d.res_ser  = (c_q.state == ST_SERSTL) || (c_q.state == ST_SQUASH && c_q.res_ser);
            c_d.res_unb  = (c_q.state == ST_UNBLK)  || (c_q.state == ST_SQUASH && c_q.res_unb);
            sk_clr       = 1'b1;
        end else begin
            unique case (c_q.state)
                ST_SQUASH: begin
                    sk_push_n = dec_v;
                    if (c_q.res_ser)      c_d.state = ST_SERSTL;
                    else if (c_q.res_unb) c_d.state = ST_UNBLK;
                    else                  c_d.state = ST_RUN;
                    c_d.res_ser = 1'b0;
                    c_d.res_unb = 1'b0;
                end
                ST_SERSTL: begin
                    sk_push_n = dec_v;
                    if (rob_empty && !stall_c) begin
                        c_d.out_n       = CW'(1);
                        c_d.out_data[0] = c_q.hold;
                        c_d.ser_next    = c_q.hold.ser_after;
                        c_d.state       = ST_UNBLK;
                    end
                end
                ST_BLOCK: begin
                    sk_push_n = dec_v;
                    if (!stall_c) c_d.state = ST_UNBLK;
                end
                default: begin
                    if (stall_c) begin
                        sk_push_n = dec_v;
                        c_d.state = ST_BLOCK;
                    end else begin
                        c_d.out_n    = sel_emit_n;
                        c_d.out_data = sel_emit;
                        c_d.ser_next = sel_carry;
                        cons_i       = int'(sel_cons);
                        if (use_skid) begin
                            sk_pop    = sel_cons;
                            sk_push_n = dec_v;
                            rem_i     = int'(sk_fill) - cons_i + int'(dec_v);
                        end else begin
                            for (int j = 0; j < W; j++) begin
                                if (cons_i + j < W) sk_push[j] = dec_arr[cons_i + j];
                                else                sk_push[j] = '0;
                            end
                            sk_push_n = dec_v - sel_cons;
                            rem_i     = int'(dec_v) - cons_i;
                        end
                        if (sel_cap) begin
                            c_d.hold  = sel_cap_inst;
                            c_d.state = ST_SERSTL;
                        end else if (sel_stop) begin
                            c_d.state = ST_BLOCK;
                        end else if (c_q.state == ST_UNBLK) begin
                            if (rem_i == 0) begin
                                c_d.state   = ST_RUN;
                                c_d.unblock = 1'b1;
                            end
                        end else begin
                            c_d.state = (sel_avail == '0) ? ST_IDLE : ST_RUN;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign out_n      = c_q.out_n;
    assign out_bus    = c_q.out_data;
    assign unblock_o  = c_q.unblock;
    assign state_o    = c_q.state;
    assign block_o    = (c_q.state == ST_BLOCK) || (c_q.state == ST_UNBLK) ||
                        (c_q.state == ST_SERSTL);
    assign skid_ovf_o = sk_ovf;
endmodule

// File: rtl/rename_flow_ctrl_chk.sv
module rename_flow_ctrl_chk #(
    parameter int W  = 4,
    parameter int FW = 6,
    parameter int CW = $clog2(W + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          squash,
    input logic          stall_in,
    input logic          rob_empty,
    input logic [FW-1:0] free_rob,
    input logic [FW-1:0] free_iq,
    input logic [CW-1:0] out_n,
    input logic [2:0]    state_o,
    input logic          block_o,
    input logic          unblock_o,
    input logic          skid_ovf_o
);
    AST_OUT_WITHIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        int'(out_n) <= W); // R1
    AST_ROB_IQ_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_n != '0) |-> (int'(out_n) <= int'($past(free_rob)) && int'(out_n) <= int'($past(free_iq)))); // R1
    AST_STALL_SENDS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_in |=> (out_n == '0)); // R2
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(skid_ovf_o) |-> skid_ovf_o); // R4
    AST_UNBLOCK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        unblock_o |-> (!block_o && $past(state_o) == 3'd3)); // R5
    AST_SQUASH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (out_n == '0 && state_o == 3'd4)); // R6
    AST_SER_WAITS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == 3'd5 && state_o == 3'd3) |-> $past(rob_empty)); // R8
endmodule

bind rename_flow_ctrl rename_flow_ctrl_chk #(.W(W), .FW(FW), .CW(CW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .squash     (squash),
    .stall_in   (stall_in),
    .rob_empty  (rob_empty),
    .free_rob   (free_rob),
    .free_iq    (free_iq),
    .out_n      (out_n),
    .state_o    (state_o),
    .block_o    (block_o),
    .unblock_o  (unblock_o),
    .skid_ovf_o (skid_ovf_o)
);

// File: tb/test_rename_flow_ctrl.sv
module test_rename_flow_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 4;
    localparam int FW = 6;
    localparam int CW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW-1:0]   dec_n = '0;
    logic [W*12-1:0] dec_bus = '0;
    logic [FW-1:0]   free_rob = 20, free_iq = 20, free_lq = 8, free_sq = 8;
    logic            rob_empty = 1'b0, stall_in = 1'b0, squash = 1'b0;
    logic [CW-1:0]   out_n;
    logic [W*12-1:0] out_bus;
    logic            block_o, unblock_o, skid_ovf_o;
    logic [2:0]      state_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    rename_flow_ctrl #(.W(W), .FW(FW)) i_rename_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .dec_n(dec_n), .dec_bus(dec_bus),
        .free_rob(free_rob), .free_iq(free_iq), .free_lq(free_lq), .free_sq(free_sq),
        .rob_empty(rob_empty), .stall_in(stall_in), .squash(squash),
        .out_n(out_n), .out_bus(out_bus), .block_o(block_o), .unblock_o(unblock_o),
        .state_o(state_o), .skid_ovf_o(skid_ovf_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] mk(int tag, bit ld, bit st, bit at, bit sb, bit sa, bit sq);
        return {sq, sa, sb, at, st, ld, 6'(tag)};
    endfunction

    function automatic int otag(int k);
        return int'(out_bus[k*12 +: 6]);
    endfunction

    task automatic chk(input string rq, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic put(input int n, input logic [11:0] a, input logic [11:0] b,
                       input logic [11:0] c, input logic [11:0] d);
        dec_n   = CW'(n);
        dec_bus = {d, c, b, a};
    endtask

    task automatic do_reset();
        rst_n = 1'b0; dec_n = '0; dec_bus = '0;
        free_rob = 20; free_iq = 20; free_lq = 8; free_sq = 8;
        rob_empty = 1'b0; stall_in = 1'b0; squash = 1'b0;
        repeat (2) @(posedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        // R12 reset state
        chk("R12 state", int'(state_o), 0);
        chk("R12 out_n", int'(out_n), 0);
        chk("R12 block", int'(block_o), 0);
        chk("R12 unblock", int'(unblock_o), 0);
        chk("R12 ovf", int'(skid_ovf_o), 0);

        // R1 / R2 / R11 sweep over free ROB/IQ counts and group size
        for (int rob = 0; rob <= 5; rob++) begin
            for (int iq = 0; iq <= 5; iq++) begin
                for (int n = 0; n <= 4; n++) begin
                    int lim;
                    int est;
                    do_reset();
                    free_rob = FW'(rob); free_iq = FW'(iq);
                    put(n, mk(1,0,0,0,0,0,0), mk(2,0,0,0,0,0,0), mk(3,0,0,0,0,0,0), mk(4,0,0,0,0,0,0));
                    tick();
                    lim = n;
                    if (rob < lim) lim = rob;
                    if (iq < lim) lim = iq;
                    if (rob == 0 || iq == 0) begin lim = 0; est = 2; end
                    else if (lim < n) est = 2;
                    else if (n == 0) est = 0;
                    else est = 1;
                    chk("R1 count", int'(out_n), lim);
                    chk("R11 state", int'(state_o), est);
                    for (int k = 0; k < lim; k++) chk("R1 order", otag(k), k + 1);
                    if (rob == 0 || iq == 0) chk("R2 block", int'(block_o), 1);
                end
            end
        end

        // R3 load/store/atomic queue limits
        for (int kind = 0; kind < 3; kind++) begin
            for (int lim = 1; lim <= 4; lim++) begin
                logic [11:0] e;
                do_reset();
                if (kind == 0) free_lq = FW'(lim); else free_sq = FW'(lim);
                e = mk(9, kind == 0, kind == 1, kind == 2, 0, 0, 0);
                put(4, e, e, e, e);
                tick();
                chk("R3 lsq count", int'(out_n), lim);
                chk("R3 lsq state", int'(state_o), (lim < 4) ? 2 : 1);
            end
        end

        // R3 / R5 mixed group: second load stops, remainder kept in order
        do_reset();
        free_lq = 1;
        put(4, mk(1,1,0,0,0,0,0), mk(2,0,1,0,0,0,0), mk(3,1,0,0,0,0,0), mk(4,0,0,0,0,0,0));
        tick();
        chk("R3 mixed count", int'(out_n), 2);
        chk("R3 mixed tag1", otag(1), 2);
        chk("R3 mixed state", int'(state_o), 2);
        free_lq = 8; put(0, '0, '0, '0, '0);
        tick();
        chk("R5 to unblocking", int'(state_o), 3);
        chk("R5 silent hop", int'(out_n), 0);
        tick();
        chk("R3 kept count", int'(out_n), 2);
        chk("R3 kept tag0", otag(0), 3);
        chk("R3 kept tag1", otag(1), 4);
        chk("R5 running", int'(state_o), 1);
        chk("R5 unblock", int'(unblock_o), 1);

        // R2 zero load-queue blocks plain instructions
        do_reset();
        free_lq = 0;
        put(1, mk(5,0,0,0,0,0,0), '0, '0, '0);
        tick();
        chk("R2 lq zero", int'(out_n), 0);
        chk("R2 lq zero state", int'(state_o), 2);

        // R4 / R5 skid drain ordering with late decode input
        do_reset();
        free_rob = 2;
        put(4, mk(1,0,0,0,0,0,0), mk(2,0,0,0,0,0,0), mk(3,0,0,0,0,0,0), mk(4,0,0,0,0,0,0));
        tick();
        chk("R1 rob cap", int'(out_n), 2);
        chk("R2 block_o", int'(block_o), 1);
        free_rob = 20; put(0, '0, '0, '0, '0);
        tick();
        chk("R5 unblocking", int'(state_o), 3);
        put(1, mk(5,0,0,0,0,0,0), '0, '0, '0);
        tick();
        chk("R5 skid first n", int'(out_n), 2);
        chk("R5 skid first tag", otag(0), 3);
        chk("R5 still unblocking", int'(state_o), 3);
        chk("R5 no pulse yet", int'(unblock_o), 0);
        put(0, '0, '0, '0, '0);
        tick();
        chk("R4 late input tag", otag(0), 5);
        chk("R5 pulse", int'(unblock_o), 1);
        chk("R5 block low", int'(block_o), 0);
        tick();
        chk("R5 pulse one cycle", int'(unblock_o), 0);
        chk("R11 idle", int'(state_o), 0);

        // R4 overflow while stalled
        do_reset();
        stall_in = 1'b1;
        put(4, mk(1,0,0,0,0,0,0), mk(2,0,0,0,0,0,0), mk(3,0,0,0,0,0,0), mk(4,0,0,0,0,0,0));
        tick();
        chk("R2 stall out", int'(out_n), 0);
        chk("R2 stall state", int'(state_o), 2);
        put(4, mk(5,0,0,0,0,0,0), mk(6,0,0,0,0,0,0), mk(7,0,0,0,0,0,0), mk(8,0,0,0,0,0,0));
        tick();
        chk("R4 full no ovf", int'(skid_ovf_o), 0);
        put(1, mk(9,0,0,0,0,0,0), '0, '0, '0);
        tick();
        chk("R4 ovf set", int'(skid_ovf_o), 1);
        stall_in = 1'b0; put(0, '0, '0, '0, '0);
        tick();
        chk("R4 ovf sticky", int'(skid_ovf_o), 1);
        tick();
        chk("R5 drain a", otag(0), 1);
        chk("R5 drain a3", otag(3), 4);
        tick();
        chk("R5 drain b", otag(0), 5);
        chk("R5 drain b3", otag(3), 8);
        chk("R5 drained", int'(state_o), 1);

        // R9 / R8 serialize-after marks next in group
        do_reset();
        put(3, mk(10,0,0,0,0,1,0), mk(11,0,0,0,0,0,0), mk(12,0,0,0,0,0,0), '0);
        tick();
        chk("R9 sa sent", int'(out_n), 1);
        chk("R9 sa tag", otag(0), 10);
        chk("R8 ser stall", int'(state_o), 5);
        put(0, '0, '0, '0, '0);
        tick();
        chk("R8 waits rob", int'(out_n), 0);
        chk("R8 still stalled", int'(state_o), 5);
        rob_empty = 1'b1;
        tick();
        chk("R8 release n", int'(out_n), 1);
        chk("R8 release tag", otag(0), 11);
        chk("R8 sb cleared", int'(out_bus[9]), 0);
        chk("R8 to unblocking", int'(state_o), 3);
        rob_empty = 1'b0;
        tick();
        chk("R8 follower", otag(0), 12);
        chk("R8 follower unblock", int'(unblock_o), 1);

        // R9 pending mark applied to next arrival
        do_reset();
        put(1, mk(20,0,0,0,0,1,0), '0, '0, '0);
        tick();
        chk("R9 lone sa", int'(out_n), 1);
        chk("R9 lone state", int'(state_o), 1);
        put(1, mk(21,0,0,0,0,0,0), '0, '0, '0);
        tick();
        chk("R9 next held", int'(out_n), 0);
        chk("R9 next stalls", int'(state_o), 5);
        put(0, '0, '0, '0, '0); rob_empty = 1'b1;
        tick();
        chk("R9 next released", otag(0), 21);

        // R10 squashed instructions dropped
        do_reset();
        put(4, mk(1,0,0,0,0,0,1), mk(2,0,0,0,0,0,0), mk(3,0,0,0,0,0,1), mk(4,0,0,0,0,0,0));
        tick();
        chk("R10 count", int'(out_n), 2);
        chk("R10 tag0", otag(0), 2);
        chk("R10 tag1", otag(1), 4);

        // R6 / R7 squash during serialize stall
        do_reset();
        put(2, mk(30,0,0,0,0,1,0), mk(31,0,0,0,0,0,0), '0, '0);
        tick();
        chk("R8 stall pre-squash", int'(state_o), 5);
        squash = 1'b1; put(1, mk(40,0,0,0,0,0,0), '0, '0, '0);
        tick();
        chk("R6 squashing", int'(state_o), 4);
        chk("R6 nothing out", int'(out_n), 0);
        squash = 1'b0; put(0, '0, '0, '0, '0);
        tick();
        chk("R7 resume serialize", int'(state_o), 5);
        rob_empty = 1'b1;
        tick();
        chk("R7 held survives", otag(0), 31);
        rob_empty = 1'b0;
        tick();
        chk("R6 input dropped", int'(out_n), 0);
        chk("R6 back running", int'(state_o), 1);

        // R6 / R7 squash during unblocking clears skid
        do_reset();
        free_rob = 2;
        put(4, mk(1,0,0,0,0,0,0), mk(2,0,0,0,0,0,0), mk(3,0,0,0,0,0,0), mk(4,0,0,0,0,0,0));
        tick();
        free_rob = 20; put(0, '0, '0, '0, '0);
        tick();
        chk("R5 pre-squash unblk", int'(state_o), 3);
        squash = 1'b1;
        tick();
        chk("R6 squash state", int'(state_o), 4);
        squash = 1'b0;
        tick();
        chk("R7 resume unblocking", int'(state_o), 3);
        tick();
        chk("R6 skid cleared", int'(out_n), 0);
        chk("R7 unblock after squash", int'(unblock_o), 1);

        // R7 squash while running
        do_reset();
        put(1, mk(7,0,0,0,0,0,0), '0, '0, '0);
        tick();
        squash = 1'b1; put(0, '0, '0, '0, '0);
        tick();
        chk("R6 from running", int'(state_o), 4);
        squash = 1'b0;
        tick();
        chk("R7 to running", int'(state_o), 1);

        finish_run();
    end
endmodule